// File: doc/BRIEF.md
# Legacy PC Memory Region Decoder

This block sits between the request ports of a PC-compatible platform (the CPU and DMA engines) and the memory targets behind them. For each byte of a request it works out which target owns the physical address: main RAM, the protected system-management RAM window, shadow RAM in the legacy 0xC0000–0xFFFFF area, the expansion ROM, the BIOS image, a device window, or nothing at all. It then emits one target beat per byte with the target select, the address inside that target and, for writes, the data byte.

A request carries a start address, a byte count of one to eight, a write flag, a CPU/DMA flag and up to eight little-endian data bytes. The block walks the bytes in increasing address order, one per cycle, so a request may span several regions. Per-segment shadow enables, the management-window controls and the BIOS write enable are live inputs that the decode reads on every beat. A request whose bytes do not all sit in one 4 KiB page is refused with an error pulse, and no beats are issued for it.

Top module: `legacy_mem_decoder`

## Requirements
- R1: Addresses below 0xA0000, and addresses from 0x100000 up to but not including RAM_BYTES (default 16 MiB), select RAM (code 0) with the target address equal to the physical address.
- R2: In 0xA0000–0xBFFFF a CPU access selects management RAM (code 1, address unchanged) when mgmtAvail is set and either mgmtOpen is set or cpuMgmtMode is set while mgmtLock is clear. A CPU access that fails this test selects the device window (code 5), and a DMA access (reqIsCpu=0) always selects drop (code 7).
- R3: In 0xC0000–0xFFFFF the segment index is address bits [17:14], and any index above 12 (the 0xF0000 segment) uses the controls at bit 12 of segRdEn and segWrEn.
- R4: A read in 0xC0000–0xFFFFF selects shadow RAM (code 2, address unchanged) when shadowCtlEn and the segment's segRdEn bit are both set. Otherwise 0xE0000–0xFFFFF selects BIOS (code 4) at offset BIOS_BYTES−0x20000+addr[16:0], and 0xC0000–0xDFFFF selects expansion ROM (code 3) at offset BIOS_BYTES+addr[16:0].
- R5: A write in 0xC0000–0xFFFFF with shadowCtlEn set selects shadow RAM when the segment's segWrEn bit is set. Failing that, when the address is at or above 0xE0000 and biosWrEn is set, it selects BIOS at the offset given in R4. Any other such write selects drop.
- R6: With shadowCtlEn clear, every read in 0xC0000–0xFFFFF comes from ROM as in R4, and every write there selects drop, whatever the segment bits hold.
- R7: Addresses from 2^32−BIOS_BYTES up to 0xFFFFFFFF select BIOS at offset addr mod BIOS_BYTES. Reads always do this, and writes do it only when biosWrEn is set (otherwise drop).
- R8: A read at any address not claimed by R1–R7, including every address at or above 4 GiB, selects fill (code 6) with tgtData equal to 0xFF. A write there selects drop.
- R9: A request whose first and last byte lie in different 4 KiB pages raises reqErr for one cycle, in the cycle after acceptance, and issues no beats.
- R10: A request is accepted on a clock edge where reqValid and reqReady are both high. Beat i is presented, with tgtValid high, in the (i+1)-th cycle after acceptance at address reqAddr+i. reqReady stays low while beats are issued.
- R11: reqDone is high for exactly the one cycle following the last beat.
- R12: A write beat i has tgtWrite high and tgtData equal to reqWdata[8i+7:8i]. A read beat has tgtWrite low and tgtData 0x00, except for a fill beat.
- R13: While reset is held, and just after it, tgtValid, reqDone and reqErr are low and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to accept |
| reqAddr | input | ADDR_W | Physical address of the first byte |
| reqLenM1 | input | LEN_W | Byte count minus one |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIsCpu | input | 1 | 1 = CPU initiator, 0 = DMA initiator |
| reqWdata | input | 8*MAX_BYTES | Write bytes, byte i in bits [8i+7:8i] |
| mgmtAvail | input | 1 | Management RAM is present |
| mgmtOpen | input | 1 | Management RAM open to all CPU accesses |
| mgmtLock | input | 1 | Management RAM locked against management-mode access |
| cpuMgmtMode | input | 1 | CPU is in management mode |
| shadowCtlEn | input | 1 | Per-segment shadow controls active |
| segRdEn | input | SEG_COUNT | Per-segment shadow read enable |
| segWrEn | input | SEG_COUNT | Per-segment shadow write enable |
| biosWrEn | input | 1 | BIOS image writable |
| tgtValid | output | 1 | Beat present |
| tgtSel | output | 3 | Target code (see R1–R8) |
| tgtAddr | output | ADDR_W | Address within the selected target |
| tgtWrite | output | 1 | Beat is a write |
| tgtData | output | 8 | Write byte, or 0xFF on a fill beat |
| reqDone | output | 1 | One-cycle pulse after the last beat |
| reqErr | output | 1 | One-cycle pulse for a refused page-crossing request |

## Verification
Acceptance happens on the rising edge at which reqValid is seen with reqReady high. The first beat is driven from registers loaded on that edge, so it is due one cycle later, and each later beat follows one cycle after the one before. reqDone and reqErr are each registered once more, so they arrive in the cycle after the final beat and in the cycle after acceptance respectively. The bench drives every input on the falling edge and samples one time unit after each rising edge, so every sample lands inside the cycle in which the value is due. Beat i is compared against a model of the address map worked out from the requirements, then the done pulse is checked after exactly lenM1+1 beats.

// File: rtl/lmd_pkg.sv
package lmd_pkg;
  // Target codes seen on tgtSel
  typedef enum logic [2:0] {
    TGT_RAM    = 3'd0,
    TGT_MGMT   = 3'd1,
    TGT_SHADOW = 3'd2,
    TGT_EXPROM = 3'd3,
    TGT_BIOS   = 3'd4,
    TGT_DEVICE = 3'd5,
    TGT_FILL   = 3'd6,
    TGT_DROP   = 3'd7
  } tgt_e;

  // 16 KiB legacy segments C0000..F0000 (F4000 and above fold onto F0000)
  localparam int SEG_COUNT = 13;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
    logic flagErr;
  } ctrl_s;
endpackage

// File: rtl/lmd_decode.sv
module lmd_decode
  import lmd_pkg::*;
#(
  parameter int              ADDR_W     = 36,
  parameter longint unsigned RAM_BYTES  = 64'h0100_0000,
  parameter longint unsigned BIOS_BYTES = 64'h0002_0000
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 isWrite,
  input  logic                 isCpu,
  input  logic                 mgmtAvail,
  input  logic                 mgmtOpen,
  input  logic                 mgmtLock,
  input  logic                 cpuMgmtMode,
  input  logic                 shadowCtlEn,
  input  logic [SEG_COUNT-1:0] segRdEn,
  input  logic [SEG_COUNT-1:0] segWrEn,
  input  logic                 biosWrEn,
  output tgt_e                 sel,
  output logic [ADDR_W-1:0]    tAddr
);
  localparam logic [ADDR_W-1:0] MGMT_LO   = ADDR_W'(64'h000A_0000);
  localparam logic [ADDR_W-1:0] LEG_LO    = ADDR_W'(64'h000C_0000);
  localparam logic [ADDR_W-1:0] HIGH_LO   = ADDR_W'(64'h0010_0000);
  localparam logic [ADDR_W-1:0] RAM_TOP   = ADDR_W'(RAM_BYTES);
  localparam logic [ADDR_W-1:0] BIOS_BASE = ADDR_W'(64'h1_0000_0000 - BIOS_BYTES);
  localparam logic [ADDR_W-1:0] BIOS_END  = ADDR_W'(64'h0_FFFF_FFFF);
  localparam logic [ADDR_W-1:0] BIOS_MASK = ADDR_W'(BIOS_BYTES - 64'd1);
  localparam logic [ADDR_W-1:0] TOP128    = ADDR_W'(BIOS_BYTES - 64'h2_0000);
  localparam logic [ADDR_W-1:0] EXP_BASE  = ADDR_W'(BIOS_BYTES);
  localparam logic [3:0]        SEG_MAX   = 4'(SEG_COUNT - 1);

  logic inMgmt, inLeg, inRam, inBios, upperLeg, mgmtGrant;
  logic [3:0] rawSeg, segIdx;
  logic [ADDR_W-1:0] romOff;

  assign inMgmt    = (addr >= MGMT_LO) && (addr < LEG_LO);
  assign inLeg     = (addr >= LEG_LO) && (addr < HIGH_LO);
  assign inRam     = (addr < MGMT_LO) || ((addr >= HIGH_LO) && (addr < RAM_TOP));
  assign inBios    = (addr >= BIOS_BASE) && (addr <= BIOS_END);
  assign rawSeg    = addr[17:14];
  assign segIdx    = (rawSeg > SEG_MAX) ? SEG_MAX : rawSeg;
  assign upperLeg  = addr[17];
  assign romOff    = upperLeg ? (TOP128 + ADDR_W'(addr[16:0]))
                              : (EXP_BASE + ADDR_W'(addr[16:0]));
  assign mgmtGrant = mgmtAvail && (mgmtOpen || (cpuMgmtMode && !mgmtLock));

  always_comb begin
    sel   = TGT_DROP;
    tAddr = addr;
    if (inMgmt) begin
      if (!isCpu)         sel = TGT_DROP;
      else if (mgmtGrant) sel = TGT_MGMT;
      else                sel = TGT_DEVICE;
    end else if (inLeg) begin
      if (isWrite) begin
        if (shadowCtlEn && segWrEn[segIdx]) begin
          sel = TGT_SHADOW;
        end else if (shadowCtlEn && upperLeg && biosWrEn) begin
          sel   = TGT_BIOS;
          tAddr = romOff;
        end
      end else if (shadowCtlEn && segRdEn[segIdx]) begin
        sel = TGT_SHADOW;
      end else begin
        sel   = upperLeg ? TGT_BIOS : TGT_EXPROM;
        tAddr = romOff;
      end
    end else if (inRam) begin
      sel = TGT_RAM;
    end else if (inBios) begin
      if (!isWrite || biosWrEn) begin
        sel   = TGT_BIOS;
        tAddr = addr & BIOS_MASK;
      end
    end else if (!isWrite) begin
      sel = TGT_FILL;
    end
  end
endmodule

// File: rtl/lmd_ctrl.sv
module lmd_ctrl
  import lmd_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqLenM1,
  input  logic             crossPage,
  output logic             reqReady,
  output logic             busy,
  output logic             reqDone,
  output logic             reqErr,
  output ctrl_s            strb
);
  logic             busyQ;
  logic [LEN_W-1:0] left;
  logic             accept;

  assign accept       = reqValid && !busyQ;
  assign strb.load    = accept && !crossPage;
  assign strb.flagErr = accept && crossPage;
  assign strb.step    = busyQ && (left != '0);
  assign strb.finish  = busyQ && (left == '0);
  assign reqReady     = !busyQ;
  assign busy         = busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      left    <= '0;
      reqDone <= 1'b0;
      reqErr  <= 1'b0;
    end else begin
      reqDone <= strb.finish;
      reqErr  <= strb.flagErr;
      if (strb.load) begin
        busyQ <= 1'b1;
        left  <= reqLenM1;
      end else if (strb.finish) begin
        busyQ <= 1'b0;
      end else if (strb.step) begin
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/lmd_datapath.sv
module lmd_datapath
  import lmd_pkg::*;
#(
  parameter int              ADDR_W     = 36,
  parameter int              MAX_BYTES  = 8,
  parameter int              LEN_W      = 3,
  parameter longint unsigned RAM_BYTES  = 64'h0100_0000,
  parameter longint unsigned BIOS_BYTES = 64'h0002_0000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_s                  strb,
  input  logic                   busy,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [LEN_W-1:0]       reqLenM1,
  input  logic                   reqWrite,
  input  logic                   reqIsCpu,
  input  logic [8*MAX_BYTES-1:0] reqWdata,
  input  logic                   mgmtAvail,
  input  logic                   mgmtOpen,
  input  logic                   mgmtLock,
  input  logic                   cpuMgmtMode,
  input  logic                   shadowCtlEn,
  input  logic [SEG_COUNT-1:0]   segRdEn,
  input  logic [SEG_COUNT-1:0]   segWrEn,
  input  logic                   biosWrEn,
  output logic                   crossPage,
  output logic [ADDR_W-1:0]      curAddr,
  output logic                   curIsCpu,
  output logic                   tgtValid,
  output tgt_e                   tgtSel,
  output logic [ADDR_W-1:0]      tgtAddr,
  output logic                   tgtWrite,
  output logic [7:0]             tgtData
);
  localparam int DATA_W = 8 * MAX_BYTES;

  logic              curWrite;
  logic [DATA_W-1:0] dataSh;
  logic [12:0]       endOff;

  // last byte offset within the page of the first byte
  assign endOff    = {1'b0, reqAddr[11:0]} + 13'(reqLenM1);
  assign crossPage = endOff[12];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWrite <= 1'b0;
      curIsCpu <= 1'b0;
      dataSh   <= '0;
    end else if (strb.load) begin
      curAddr  <= reqAddr;
      curWrite <= reqWrite;
      curIsCpu <= reqIsCpu;
      dataSh   <= reqWdata;
    end else if (strb.step) begin
      curAddr  <= curAddr + 1'b1;
      dataSh   <= dataSh >> 8;
    end
  end

  lmd_decode #(
    .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .BIOS_BYTES(BIOS_BYTES)
  ) u_decode (
    .addr(curAddr), .isWrite(curWrite), .isCpu(curIsCpu),
    .mgmtAvail(mgmtAvail), .mgmtOpen(mgmtOpen), .mgmtLock(mgmtLock),
    .cpuMgmtMode(cpuMgmtMode), .shadowCtlEn(shadowCtlEn),
    .segRdEn(segRdEn), .segWrEn(segWrEn), .biosWrEn(biosWrEn),
    .sel(tgtSel), .tAddr(tgtAddr)
  );

  assign tgtValid = busy;
  assign tgtWrite = busy && curWrite;
  assign tgtData  = (tgtSel == TGT_FILL) ? 8'hFF
                  : (curWrite ? dataSh[7:0] : 8'h00);
endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
  import lmd_pkg::*;
#(
  parameter int              ADDR_W     = 36,
  parameter int              MAX_BYTES  = 8,
  parameter longint unsigned RAM_BYTES  = 64'h0100_0000,
  parameter longint unsigned BIOS_BYTES = 64'h0002_0000,
  localparam int             LEN_W      = $clog2(MAX_BYTES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [LEN_W-1:0]       reqLenM1,
  input  logic                   reqWrite,
  input  logic                   reqIsCpu,
  input  logic [8*MAX_BYTES-1:0] reqWdata,
  input  logic                   mgmtAvail,
  input  logic                   mgmtOpen,
  input  logic                   mgmtLock,
  input  logic                   cpuMgmtMode,
  input  logic                   shadowCtlEn,
  input  logic [SEG_COUNT-1:0]   segRdEn,
  input  logic [SEG_COUNT-1:0]   segWrEn,
  input  logic                   biosWrEn,
  output logic                   tgtValid,
  output logic [2:0]             tgtSel,
  output logic [ADDR_W-1:0]      tgtAddr,
  output logic                   tgtWrite,
  output logic [7:0]             tgtData,
  output logic                   reqDone,
  output logic                   reqErr
);
  ctrl_s             strb;
  logic              busy, crossPage, curIsCpu;
  logic [ADDR_W-1:0] curAddr;
  tgt_e              selE;

  lmd_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLenM1(reqLenM1),
    .crossPage(crossPage), .reqReady(reqReady), .busy(busy),
    .reqDone(reqDone), .reqErr(reqErr), .strb(strb)
  );

  lmd_datapath #(
    .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W),
    .RAM_BYTES(RAM_BYTES), .BIOS_BYTES(BIOS_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .reqAddr(reqAddr), .reqLenM1(reqLenM1), .reqWrite(reqWrite),
    .reqIsCpu(reqIsCpu), .reqWdata(reqWdata),
    .mgmtAvail(mgmtAvail), .mgmtOpen(mgmtOpen), .mgmtLock(mgmtLock),
    .cpuMgmtMode(cpuMgmtMode), .shadowCtlEn(shadowCtlEn),
    .segRdEn(segRdEn), .segWrEn(segWrEn), .biosWrEn(biosWrEn),
    .crossPage(crossPage), .curAddr(curAddr), .curIsCpu(curIsCpu),
    .tgtValid(tgtValid), .tgtSel(selE), .tgtAddr(tgtAddr),
    .tgtWrite(tgtWrite), .tgtData(tgtData)
  );

  assign tgtSel = selE;
endmodule

// File: rtl/lmd_checker.sv
module lmd_checker #(
  parameter int ADDR_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              tgtValid,
  input logic [2:0]        tgtSel,
  input logic              tgtWrite,
  input logic [7:0]        tgtData,
  input logic              reqDone,
  input logic              reqErr,
  input logic [ADDR_W-1:0] curAddr,
  input logic              curIsCpu
);
  // R2: DMA never reaches management RAM
  p_dma_no_mgmt_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tgtValid && !curIsCpu) |-> (tgtSel != 3'd1));

  // R8: fill beats are reads returning all ones
  p_fill_ones_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tgtValid && tgtSel == 3'd6) |-> (tgtData == 8'hFF && !tgtWrite));

  // R9: a refused request issues no beat
  p_err_no_beat_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> !tgtValid);

  // R10: no acceptance while beats are flowing
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    tgtValid |-> !reqReady);

  // R10: consecutive beats step the address by one
  p_addr_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (tgtValid && $past(tgtValid)) |-> (curAddr == $past(curAddr) + ADDR_W'(1)));

  // R11: the end of a beat run is followed by done
  p_done_after_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tgtValid) |-> reqDone);

  // R11: done only after a beat
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> (!tgtValid && $past(tgtValid)));
endmodule

bind legacy_mem_decoder lmd_checker #(.ADDR_W(ADDR_W)) u_lmd_checker (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .tgtValid(tgtValid),
  .tgtSel(tgtSel), .tgtWrite(tgtWrite), .tgtData(tgtData),
  .reqDone(reqDone), .reqErr(reqErr), .curAddr(curAddr), .curIsCpu(curIsCpu)
);

// File: tb/legacy_mem_decoder_test.sv
module legacy_mem_decoder_test;
  localparam int AW = 36;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic [2:0]    reqLenM1 = '0;
  logic          reqWrite = 1'b0;
  logic          reqIsCpu = 1'b1;
  logic [63:0]   reqWdata = '0;
  logic          mgmtAvail = 1'b0, mgmtOpen = 1'b0, mgmtLock = 1'b0, cpuMgmtMode = 1'b0;
  logic          shadowCtlEn = 1'b0;
  logic [12:0]   segRdEn = '0, segWrEn = '0;
  logic          biosWrEn = 1'b0;
  logic          tgtValid, tgtWrite, reqDone, reqErr;
  logic [2:0]    tgtSel;
  logic [AW-1:0] tgtAddr;
  logic [7:0]    tgtData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  legacy_mem_decoder uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLenM1(reqLenM1), .reqWrite(reqWrite),
    .reqIsCpu(reqIsCpu), .reqWdata(reqWdata),
    .mgmtAvail(mgmtAvail), .mgmtOpen(mgmtOpen), .mgmtLock(mgmtLock),
    .cpuMgmtMode(cpuMgmtMode), .shadowCtlEn(shadowCtlEn),
    .segRdEn(segRdEn), .segWrEn(segWrEn), .biosWrEn(biosWrEn),
    .tgtValid(tgtValid), .tgtSel(tgtSel), .tgtAddr(tgtAddr),
    .tgtWrite(tgtWrite), .tgtData(tgtData), .reqDone(reqDone), .reqErr(reqErr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Address map model: 16 MiB RAM, 128 KiB BIOS image at FFFE0000
  function automatic logic [AW+2:0] model(input logic [AW-1:0] a, input bit wr, input bit cpu);
    logic [2:0] s;
    logic [AW-1:0] t;
    int seg;
    t = a;
    seg = int'(a[17:14]);
    if (seg > 12) seg = 12;
    if (a >= 36'hA0000 && a <= 36'hBFFFF) begin
      if (!cpu) s = 3'd7;
      else if (mgmtAvail && (mgmtOpen || (cpuMgmtMode && !mgmtLock))) s = 3'd1;
      else s = 3'd5;
    end else if (a >= 36'hC0000 && a <= 36'hFFFFF) begin
      if (wr) begin
        if (shadowCtlEn && segWrEn[seg]) s = 3'd2;
        else if (shadowCtlEn && a >= 36'hE0000 && biosWrEn) begin s = 3'd4; t = a - 36'hE0000; end
        else s = 3'd7;
      end else if (shadowCtlEn && segRdEn[seg]) s = 3'd2;
      else if (a >= 36'hE0000) begin s = 3'd4; t = a - 36'hE0000; end
      else begin s = 3'd3; t = a - 36'hC0000 + 36'h20000; end
    end else if (a < 36'hA0000 || a < 36'h1000000) begin
      s = 3'd0;
    end else if (a >= 36'hFFFE0000 && a <= 36'hFFFFFFFF) begin
      if (!wr || biosWrEn) begin s = 3'd4; t = a - 36'hFFFE0000; end
      else s = 3'd7;
    end else begin
      s = wr ? 3'd7 : 3'd6;
    end
    return {s, t};
  endfunction

  task automatic runReq(input string req, input logic [AW-1:0] a, input logic [2:0] lenM1,
                        input bit wr, input bit cpu, input logic [63:0] wd);
    @(negedge clk);
    reqAddr = a; reqLenM1 = lenM1; reqWrite = wr; reqIsCpu = cpu; reqWdata = wd;
    reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    for (int i = 0; i <= int'(lenM1); i++) begin
      logic [AW+2:0] e;
      logic [7:0] ed;
      e = model(a + AW'(i), wr, cpu);
      ed = (e[AW+2:AW] == 3'd6) ? 8'hFF : (wr ? wd[8*i +: 8] : 8'h00);
      check(tgtValid && !reqReady && tgtSel == e[AW+2:AW] && tgtAddr == e[AW-1:0]
            && tgtWrite == wr && tgtData == ed,
            $sformatf("%s beat %0d", req, i),
            {tgtValid, reqReady, tgtWrite, tgtSel, tgtData, 14'd0, tgtAddr},
            {1'b1, 1'b0, wr, e[AW+2:AW], ed, 14'd0, e[AW-1:0]});
      @(posedge clk); #1;
    end
    check(reqDone && !tgtValid && reqReady, {req, " R11 done"},
          64'({reqDone, tgtValid, reqReady}), 64'b101);
    @(posedge clk); #1;
    check(!reqDone, {req, " R11 done one cycle"}, 64'(reqDone), 64'd0);
  endtask

  task automatic testReset();
    check(!tgtValid && !reqDone && !reqErr && reqReady, "R13 reset",
          64'({tgtValid, reqDone, reqErr, reqReady}), 64'b0001);
  endtask

  task automatic testRam();
    runReq("R1 R10 low ram read", 36'h0_1000, 3'd3, 1'b0, 1'b1, 64'h0);
    runReq("R1 R12 high ram write", 36'h20_0FFC, 3'd3, 1'b1, 1'b1, 64'h0000_0000_DDCC_BBAA);
    runReq("R1 ram top byte", 36'hFF_FFFF, 3'd0, 1'b0, 1'b0, 64'h0);
  endtask

  task automatic testMgmt();
    mgmtAvail = 1'b1; mgmtOpen = 1'b1;
    runReq("R2 open cpu", 36'hA_0000, 3'd1, 1'b0, 1'b1, 64'h0);
    runReq("R2 dma dropped", 36'hA_0010, 3'd1, 1'b1, 1'b0, 64'h1122);
    mgmtOpen = 1'b0; cpuMgmtMode = 1'b1;
    runReq("R2 mgmt mode cpu", 36'hB_FFFF, 3'd0, 1'b1, 1'b1, 64'h5A);
    mgmtLock = 1'b1;
    runReq("R2 locked to device", 36'hB_0000, 3'd0, 1'b0, 1'b1, 64'h0);
    mgmtLock = 1'b0; mgmtAvail = 1'b0;
    runReq("R2 absent to device", 36'hA_8000, 3'd0, 1'b0, 1'b1, 64'h0);
    runReq("R2 dma read dropped", 36'hA_8000, 3'd0, 1'b0, 1'b0, 64'h0);
    cpuMgmtMode = 1'b0;
  endtask

  task automatic testLegacyRead();
    shadowCtlEn = 1'b1; segRdEn = 13'h0; segWrEn = 13'h0;
    runReq("R4 exp rom", 36'hC_4000, 3'd1, 1'b0, 1'b1, 64'h0);
    runReq("R4 bios low128", 36'hE_8000, 3'd0, 1'b0, 1'b1, 64'h0);
    segRdEn = 13'h002;
    runReq("R4 shadow read seg1", 36'hC_4004, 3'd2, 1'b0, 1'b1, 64'h0);
    runReq("R4 seg0 still rom", 36'hC_0000, 3'd0, 1'b0, 1'b1, 64'h0);
    segRdEn = 13'h1000;
    runReq("R3 clamp read shadow", 36'hF_C000, 3'd0, 1'b0, 1'b1, 64'h0);
    runReq("R3 clamp F4000", 36'hF_4010, 3'd0, 1'b0, 1'b1, 64'h0);
    segRdEn = 13'h0FFF;
    runReq("R3 clamp read rom", 36'hF_FFF8, 3'd7, 1'b0, 1'b1, 64'h0);
  endtask

  task automatic testLegacyWrite();
    shadowCtlEn = 1'b1; segRdEn = 13'h0; segWrEn = 13'h0; biosWrEn = 1'b0;
    runReq("R5 write dropped", 36'hE_0000, 3'd1, 1'b1, 1'b1, 64'h0201);
    biosWrEn = 1'b1;
    runReq("R5 write to bios", 36'hF_0000, 3'd1, 1'b1, 1'b1, 64'h0403);
    runReq("R5 low seg no bios", 36'hD_0000, 3'd0, 1'b1, 1'b1, 64'h07);
    segWrEn = 13'h1000;
    runReq("R5 R3 write shadow clamp", 36'hF_8000, 3'd3, 1'b1, 1'b1, 64'h89AB_CDEF);
    segWrEn = 13'h001;
    runReq("R5 write shadow seg0", 36'hC_0100, 3'd0, 1'b1, 1'b1, 64'h33);
    shadowCtlEn = 1'b0; segRdEn = 13'h1FFF; segWrEn = 13'h1FFF;
    runReq("R6 disabled read rom", 36'hC_8000, 3'd0, 1'b0, 1'b1, 64'h0);
    runReq("R6 disabled read bios", 36'hF_C000, 3'd0, 1'b0, 1'b1, 64'h0);
    runReq("R6 disabled write drop", 36'hE_4000, 3'd1, 1'b1, 1'b1, 64'hBEEF);
    biosWrEn = 1'b0; segRdEn = '0; segWrEn = '0;
  endtask

  task automatic testBiosAndFill();
    runReq("R7 bios read", 36'hFFFF_FFF0, 3'd7, 1'b0, 1'b1, 64'h0);
    runReq("R7 bios write locked", 36'hFFFE_0000, 3'd0, 1'b1, 1'b1, 64'h11);
    biosWrEn = 1'b1;
    runReq("R7 bios write open", 36'hFFFE_0100, 3'd1, 1'b1, 1'b0, 64'h2211);
    biosWrEn = 1'b0;
    runReq("R8 fill above ram", 36'h0200_0000, 3'd2, 1'b0, 1'b1, 64'h0);
    runReq("R8 fill above 4G", 36'h1_0000_0000, 3'd1, 1'b0, 1'b1, 64'h0);
    runReq("R8 fill below bios", 36'hFFFD_FFFF, 3'd0, 1'b0, 1'b1, 64'h0);
    runReq("R8 unmapped write drop", 36'h1_FFFE_0000, 3'd0, 1'b1, 1'b1, 64'h77);
  endtask

  task automatic testCross();
    @(negedge clk);
    reqAddr = 36'h0_0FFE; reqLenM1 = 3'd3; reqWrite = 1'b0; reqIsCpu = 1'b1;
    reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    check(reqErr && !tgtValid && reqReady, "R9 err pulse",
          64'({reqErr, tgtValid, reqReady}), 64'b101);
    @(posedge clk); #1;
    check(!reqErr && !tgtValid && !reqDone, "R9 err one cycle no beat",
          64'({reqErr, tgtValid, reqDone}), 64'b000);
    runReq("R9 page end fits", 36'h0_0FF8, 3'd7, 1'b0, 1'b1, 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    testReset();
    testRam();
    testMgmt();
    testLegacyRead();
    testLegacyWrite();
    testBiosAndFill();
    testCross();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule